// File: doc/BRIEF.md
# Bisync Character Transmitter

This block serialises a byte-oriented synchronous message onto a single line. Whenever the host has no character waiting, it sends a programmable idle (sync) pattern, so the line never goes quiet while transmission is enabled. The host writes data bytes one at a time into a single hold register. A data-request output tells the host when the next byte may be written. Each byte carries its own flag that says whether it takes part in the CRC-16 check sum.

Message framing is set by an end-of-message latch. To mark the last byte of a message, the host clears the latch with a command pulse. When the hold register next runs dry, the block sends the accumulated check sum, sets the latch again, raises an interrupt and falls back to sync characters. If the register runs dry while the latch is still set, this is a plain underrun: sync characters fill the gap and no check sum is sent. One bit is sent per cycle in which the bit-clock enable is high.

Top module: `bisync_tx`

## Requirements
- R1: While `tx_en` is low, `txd` is 1 from the next clock edge, even in the middle of a character. Dropping `tx_en` also empties the hold register, clears the check-sum register and drops any pending check-sum byte.
- R2: With `tx_en` high, each clock edge with `bit_en` high puts exactly one new bit on `txd`, least significant bit first. Sync and data characters are `char_len` bits long (code 0 gives 5 bits, 1 gives 6, 2 gives 7, 3 gives 8). Check-sum bytes are always 8 bits.
- R3: When no character is waiting and the latch is set, the block sends the low `char_len` bits of `sync_char`. Sync characters sent before the first data byte never enter the check sum.
- R4: The hold register stores one byte. A `wr_stb` pulse is accepted only while `tx_en` is high and the register is empty. A write while the register is full is ignored and does not change the bytes sent.
- R5: `data_req` is high when `tx_en` is high, the register is empty, and at least one data byte has started since `tx_en` rose. So the first request comes while the first data byte is on the line.
- R6: The check sum is a 16-bit register preset to zero. It is updated once for each sent data bit of a byte written with `wr_crc_incl` high while `crc_en` is high. Each update computes feedback = bit 0 XOR the data bit, shifts the register right by one, and if the feedback is 1 XORs in 0xA001 (the reversed form of x^16+x^15+x^2+1). The register is cleared when the check sum starts to be sent.
- R7: `eom_clr` clears the latch. If the register runs dry while the latch is clear, the block sends check-sum bits 15..8 (bit 8 first), then bits 7..0 (bit 0 first), then sync characters. The latch is set again as the first check-sum byte starts.
- R8: If the register runs dry while the latch is set, sync characters follow the last data character directly, and no interrupt is raised.
- R9: `irq` goes high when the block sets the latch and stays high until an `irq_ack` pulse. `eom_flag` shows the latch. The latch keeps its value until `eom_clr` or a check-sum start.
- R10: `rts_out` equals `rts_req` as it was one clock earlier.
- R11: After reset: `txd`=1, `data_req`=0, `irq`=0, `eom_flag`=1, `rts_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| bit_en | input | 1 | One-cycle strobe for each bit time |
| rts_req | input | 1 | Request-to-send from the host |
| sync_char | input | 8 | Idle pattern |
| char_len | input | 2 | Character length code, 5 to 8 bits |
| crc_en | input | 1 | Global check-sum enable |
| wr_stb | input | 1 | Data write strobe |
| wr_data | input | 8 | Data byte |
| wr_crc_incl | input | 1 | Include this byte in the check sum |
| eom_clr | input | 1 | Clear end-of-message latch |
| irq_ack | input | 1 | Clear interrupt |
| txd | output | 1 | Serial data |
| rts_out | output | 1 | Registered request-to-send |
| data_req | output | 1 | Hold register may be written |
| irq | output | 1 | Latch-set interrupt |
| eom_flag | output | 1 | End-of-message latch state |

## Verification
The bench finds where the message starts in the captured bit stream by skipping whole sync characters. A design that ran a sync character into the check sum, or sent the check-sum halves in the wrong order, shows up as a check-sum mismatch right after the data. Messages that end with the latch set must go straight back to sync. A block that sent a check sum anyway would put 16 foreign bits there and raise a stray interrupt. Other targets are short 5-bit characters, bytes excluded from the sum, an extra write into a full register (a design that accepted it would corrupt the data segment), a request line that asks before the first byte, and dropping enable mid-character, which must force the line to 1 on the next edge.

// File: rtl/bisync_pkg.sv
// Shared types for the bisync transmitter.
// Assumes: the character source is chosen once per character boundary.
package bisync_pkg;
    typedef enum logic [1:0] {
        SRC_SYNC   = 2'd0,
        SRC_DATA   = 2'd1,
        SRC_CRC_HI = 2'd2,
        SRC_CRC_LO = 2'd3
    } char_src_e;

    localparam int unsigned LEN_CODE_W = 2;
endpackage

// File: rtl/bisync_crc_acc.sv
// Bit-serial check-sum accumulator, right-shifting (reflected) form.
// Assumes: clr and step are never both wanted in the same cycle; clr wins.
module bisync_crc_acc #(
    parameter int unsigned    W    = 16,
    parameter logic [W-1:0]   POLY = 16'hA001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic         din,
    output logic [W-1:0] crc_q
);
    logic         fb;
    logic [W-1:0] crc_nxt;

    // next value of the register for one input bit
    always_comb begin
        fb      = crc_q[0] ^ din;
        crc_nxt = (crc_q >> 1) ^ (fb ? POLY : '0);
    end

    // register with clear and step
    always_ff @(posedge clk) begin
        if (!rst_n)    crc_q <= '0;
        else if (clr)  crc_q <= '0;
        else if (step) crc_q <= crc_nxt;
    end
endmodule

// File: rtl/bisync_shifter.sv
// Character shifter: loads a character at each boundary and emits it LSB first,
// one bit per bit_en. It also tells the check-sum accumulator when and what to update.
// Assumes: ld_len is between 1 and CHAR_W.
module bisync_shifter #(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned CNT_W  = $clog2(CHAR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              bit_en,
    input  logic [CHAR_W-1:0] ld_char,
    input  logic [CNT_W-1:0]  ld_len,
    input  logic              ld_acc,
    output logic              txd,
    output logic              take,
    output logic              step,
    output logic              step_bit
);
    logic [CHAR_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              acc_q;
    logic              fire;

    // boundary detection and check-sum feed
    always_comb begin
        fire     = run & bit_en;
        take     = fire & (cnt_q == '0);
        step     = fire & (take ? ld_acc : acc_q);
        step_bit = take ? ld_char[0] : sh_q[0];
    end

    // shift register, bit counter and line output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd   <= 1'b1;
            sh_q  <= '0;
            cnt_q <= '0;
            acc_q <= 1'b0;
        end else if (!run) begin
            txd   <= 1'b1;
            cnt_q <= '0;
            acc_q <= 1'b0;
        end else if (take) begin
            txd   <= ld_char[0];
            sh_q  <= ld_char >> 1;
            cnt_q <= ld_len - 1'b1;
            acc_q <= ld_acc;
        end else if (fire) begin
            txd   <= sh_q[0];
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/bisync_seq.sv
// Character sequencer: hold register, end-of-message latch, interrupt and
// choice of the next character (pending check-sum low byte, data,
// check-sum high byte, sync, in that priority).
// Assumes: CRC_W is twice CHAR_W; char_len codes map to CHAR_W-3 .. CHAR_W bits.
module bisync_seq
    import bisync_pkg::*;
#(
    parameter int unsigned CHAR_W = 8,
    parameter int unsigned CRC_W  = 16,
    parameter int unsigned CNT_W  = $clog2(CHAR_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  take,
    input  logic [CHAR_W-1:0]     sync_char,
    input  logic [LEN_CODE_W-1:0] char_len,
    input  logic                  crc_en,
    input  logic                  wr,
    input  logic [CHAR_W-1:0]     wr_data,
    input  logic                  wr_incl,
    input  logic                  eom_clr,
    input  logic                  irq_ack,
    input  logic [CRC_W-1:0]      crc_q,
    output logic [CHAR_W-1:0]     ld_char,
    output logic [CNT_W-1:0]      ld_len,
    output logic                  ld_acc,
    output logic                  crc_clr,
    output logic                  data_req,
    output logic                  irq,
    output logic                  eom_flag
);
    localparam int unsigned MIN_LEN = CHAR_W - 3;

    char_src_e         src;
    logic              buf_full_q;
    logic [CHAR_W-1:0] buf_data_q;
    logic              buf_incl_q;
    logic              lo_pend_q;
    logic [CHAR_W-1:0] lo_byte_q;
    logic              latch_q;
    logic              irq_q;
    logic              armed_q;
    logic [CNT_W-1:0]  user_len;
    logic              crc_start;

    // pick the source of the next character
    always_comb begin
        if (lo_pend_q)       src = SRC_CRC_LO;
        else if (buf_full_q) src = SRC_DATA;
        else if (!latch_q)   src = SRC_CRC_HI;
        else                 src = SRC_SYNC;
    end

    // present the chosen character, its length and its check-sum flag
    always_comb begin
        user_len = CNT_W'(MIN_LEN) + CNT_W'(char_len);
        ld_acc   = 1'b0;
        case (src)
            SRC_CRC_LO: begin
                ld_char = lo_byte_q;
                ld_len  = CNT_W'(CHAR_W);
            end
            SRC_DATA: begin
                ld_char = buf_data_q;
                ld_len  = user_len;
                ld_acc  = crc_en & buf_incl_q;
            end
            SRC_CRC_HI: begin
                ld_char = crc_q[CRC_W-1:CHAR_W];
                ld_len  = CNT_W'(CHAR_W);
            end
            default: begin
                ld_char = sync_char;
                ld_len  = user_len;
            end
        endcase
        crc_start = run & take & (src == SRC_CRC_HI);
        crc_clr   = ~run | crc_start;
        data_req  = run & armed_q & ~buf_full_q;
        irq       = irq_q;
        eom_flag  = latch_q;
    end

    // hold register, check-sum low byte and request arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full_q <= 1'b0;
            buf_data_q <= '0;
            buf_incl_q <= 1'b0;
            lo_pend_q  <= 1'b0;
            lo_byte_q  <= '0;
            armed_q    <= 1'b0;
        end else if (!run) begin
            buf_full_q <= 1'b0;
            lo_pend_q  <= 1'b0;
            armed_q    <= 1'b0;
        end else begin
            if (wr && !buf_full_q) begin
                buf_full_q <= 1'b1;
                buf_data_q <= wr_data;
                buf_incl_q <= wr_incl;
            end else if (take && src == SRC_DATA) begin
                buf_full_q <= 1'b0;
                armed_q    <= 1'b1;
            end
            if (crc_start) begin
                lo_pend_q <= 1'b1;
                lo_byte_q <= crc_q[CHAR_W-1:0];
            end else if (take && src == SRC_CRC_LO) begin
                lo_pend_q <= 1'b0;
            end
        end
    end

    // end-of-message latch and its interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b1;
            irq_q   <= 1'b0;
        end else begin
            if (crc_start)    latch_q <= 1'b1;
            else if (eom_clr) latch_q <= 1'b0;
            if (crc_start)    irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bisync_tx.sv
// Bisync character transmitter top: connects the sequencer, the shifter and the
// check-sum accumulator, and registers the request-to-send line.
// Assumes: bit_en is a one-cycle strobe per bit time in the clk domain.
module bisync_tx #(
    parameter int unsigned  CHAR_W   = 8,
    parameter int unsigned  CRC_W    = 2 * CHAR_W,
    parameter logic [15:0]  CRC_POLY = 16'hA001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_en,
    input  logic              rts_req,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic [1:0]        char_len,
    input  logic              crc_en,
    input  logic              wr_stb,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              wr_crc_incl,
    input  logic              eom_clr,
    input  logic              irq_ack,
    output logic              txd,
    output logic              rts_out,
    output logic              data_req,
    output logic              irq,
    output logic              eom_flag
);
    localparam int unsigned CNT_W = $clog2(CHAR_W + 1);

    logic [CHAR_W-1:0] ld_char;
    logic [CNT_W-1:0]  ld_len;
    logic              ld_acc;
    logic              take;
    logic              crc_step;
    logic              crc_bit;
    logic              crc_clr;
    logic [CRC_W-1:0]  crc_q;

    bisync_seq #(.CHAR_W(CHAR_W), .CRC_W(CRC_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .take(take),
        .sync_char(sync_char), .char_len(char_len), .crc_en(crc_en),
        .wr(wr_stb), .wr_data(wr_data), .wr_incl(wr_crc_incl),
        .eom_clr(eom_clr), .irq_ack(irq_ack), .crc_q(crc_q),
        .ld_char(ld_char), .ld_len(ld_len), .ld_acc(ld_acc),
        .crc_clr(crc_clr), .data_req(data_req), .irq(irq), .eom_flag(eom_flag)
    );

    bisync_shifter #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(tx_en), .bit_en(bit_en),
        .ld_char(ld_char), .ld_len(ld_len), .ld_acc(ld_acc),
        .txd(txd), .take(take), .step(crc_step), .step_bit(crc_bit)
    );

    bisync_crc_acc #(.W(CRC_W), .POLY(CRC_W'(CRC_POLY))) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .step(crc_step),
        .din(crc_bit), .crc_q(crc_q)
    );

    // request-to-send output register
    always_ff @(posedge clk) begin
        if (!rst_n) rts_out <= 1'b0;
        else        rts_out <= rts_req;
    end
endmodule

// File: rtl/bisync_tx_chk.sv
// Port-level checker for bisync_tx, bound to every instance of it.
module bisync_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic rts_req,
    input logic rts_out,
    input logic wr_stb,
    input logic data_req,
    input logic eom_clr,
    input logic eom_flag,
    input logic irq,
    input logic txd
);
    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n) !tx_en |=> txd); // R1
    AST_REQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) data_req |-> tx_en); // R5
    AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) (data_req && wr_stb) |=> !data_req); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (eom_flag && !eom_clr) |=> eom_flag); // R9
    AST_LATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(eom_flag) |-> irq); // R9
    AST_RTS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> (rts_out == $past(rts_req))); // R10
endmodule

bind bisync_tx bisync_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rts_req(rts_req), .rts_out(rts_out),
    .wr_stb(wr_stb), .data_req(data_req), .eom_clr(eom_clr), .eom_flag(eom_flag),
    .irq(irq), .txd(txd)
);

// File: tb/bisync_tx_tb.sv
module bisync_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, bit_en = 1'b0, rts_req = 1'b0;
    logic [7:0] sync_char = 8'h16;
    logic [1:0] char_len = 2'd3;
    logic       crc_en = 1'b0, wr_stb = 1'b0, wr_crc_incl = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       eom_clr = 1'b0, irq_ack = 1'b0;
    logic       txd, rts_out, data_req, irq, eom_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  dense = 1'b1;
    logic fire_q = 1'b0, idle_q = 1'b1;
    logic cap [0:4095];
    int  ncap = 0;
    logic exp_b [0:255];

    always #4 clk = ~clk;

    bisync_tx u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .bit_en(bit_en), .rts_req(rts_req),
        .sync_char(sync_char), .char_len(char_len), .crc_en(crc_en), .wr_stb(wr_stb),
        .wr_data(wr_data), .wr_crc_incl(wr_crc_incl), .eom_clr(eom_clr),
        .irq_ack(irq_ack), .txd(txd), .rts_out(rts_out), .data_req(data_req),
        .irq(irq), .eom_flag(eom_flag)
    );

    // bit strobe pattern, changed away from the active edge
    always @(negedge clk) bit_en = dense ? 1'b1 : (($urandom % 3) != 0);

    // note which edges should have produced a bit
    always @(posedge clk) begin
        fire_q <= bit_en & tx_en & rst_n;
        idle_q <= ~tx_en;
    end

    // capture the line after each bit-producing edge
    always @(negedge clk) begin
        if (idle_q) ncap = 0;
        else if (fire_q && ncap < 4096) begin
            cap[ncap] = txd;
            ncap++;
        end
    end

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        crc_upd = (c >> 1) ^ (fb ? 16'hA001 : 16'h0000);
    endfunction

    function automatic bit is_sync(input int base, input int len, input logic [7:0] s);
        for (int b = 0; b < len; b++)
            if (cap[base + b] !== s[b]) return 1'b0;
        return 1'b1;
    endfunction

    // first mismatching offset in [a,e) of the expected stream, -1 if none
    function automatic int seg_mis(input int off, input int a, input int e);
        for (int i = a; i < e; i++)
            if (off + i >= ncap || cap[off + i] !== exp_b[i]) return i;
        return -1;
    endfunction

    task automatic run_msg(input int n, input logic [1:0] lc, input bit cen,
                           input bit eom, input bit extra, input logic [7:0] sy);
        logic [7:0]  dat [0:15];
        bit          inc [0:15];
        logic [15:0] crc;
        int          len, k, off, idx, dend, cend, tot, w0, lim, m;
        len = 5 + int'(lc);
        tx_en = 1'b0;
        tick; tick;
        irq_ack = 1'b1; tick; irq_ack = 1'b0;
        sync_char = sy; char_len = lc; crc_en = cen;
        for (int i = 0; i < n; i++) begin
            dat[i] = 8'($urandom);
            inc[i] = 1'($urandom);
        end
        if (dat[0][0] == sy[0]) dat[0][0] = ~dat[0][0];
        crc = 16'h0000;
        for (int i = 0; i < n; i++)
            if (cen && inc[i])
                for (int b = 0; b < len; b++) crc = crc_upd(crc, dat[i][b]);
        tx_en = 1'b1;
        tick;
        repeat (2 + $urandom % 20) tick;
        chk(data_req == 1'b0, "R5 no request before first byte", data_req, 0);
        w0 = 0;
        for (int i = 0; i < n; i++) begin
            lim = 0;
            while (i > 0 && !data_req && lim < 3000) begin tick; lim++; end
            wr_stb = 1'b1; wr_data = dat[i]; wr_crc_incl = inc[i];
            eom_clr = eom && (i == n - 1);
            tick;
            wr_stb = 1'b0; eom_clr = 1'b0;
            w0 = ncap;
            if (extra && i > 0) begin
                chk(data_req == 1'b0, "R4 register full after write", data_req, 0);
                wr_stb = 1'b1; wr_data = ~dat[i]; wr_crc_incl = ~inc[i];
                tick;
                wr_stb = 1'b0;
            end
        end
        if (eom) chk(eom_flag == 1'b0, "R7 latch cleared by command", eom_flag, 0);
        lim = 0;
        while (ncap < w0 + 3 * len + 24 && lim < 5000) begin tick; lim++; end
        k = 0;
        while ((k + 1) * len <= ncap && is_sync(k * len, len, sy)) k++;
        off = k * len;
        chk(k >= 1, "R3 sync before data", k, 1);
        idx = 0;
        for (int i = 0; i < n; i++)
            for (int b = 0; b < len; b++) begin exp_b[idx] = dat[i][b]; idx++; end
        dend = idx;
        if (eom) begin
            for (int b = 8; b < 16; b++) begin exp_b[idx] = crc[b]; idx++; end
            for (int b = 0; b < 8; b++)  begin exp_b[idx] = crc[b]; idx++; end
        end
        cend = idx;
        for (int b = 0; b < len; b++) begin exp_b[idx] = sy[b]; idx++; end
        tot = idx;
        m = seg_mis(off, 0, dend);
        chk(m < 0, "R2 R4 data characters", m, -1);
        if (eom) begin
            m = seg_mis(off, dend, cend);
            chk(m < 0, "R6 R7 check sum bits", m, -1);
        end
        m = seg_mis(off, cend, tot);
        chk(m < 0, eom ? "R7 sync after check sum" : "R8 sync right after data", m, -1);
        chk(irq == eom, "R9 R8 interrupt after message", irq, eom);
        chk(eom_flag == 1'b1, "R9 latch set after message", eom_flag, 1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick;
        rst_n = 1'b1;
        tick;
        chk(txd == 1'b1, "R11 reset txd", txd, 1);
        chk(data_req == 1'b0, "R11 reset data_req", data_req, 0);
        chk(irq == 1'b0, "R11 reset irq", irq, 0);
        chk(eom_flag == 1'b1, "R11 reset eom_flag", eom_flag, 1);
        chk(rts_out == 1'b0, "R11 reset rts_out", rts_out, 0);

        rts_req = 1'b1; tick;
        chk(rts_out == 1'b1, "R10 rts follows high", rts_out, 1);
        rts_req = 1'b0; tick;
        chk(rts_out == 1'b0, "R10 rts follows low", rts_out, 0);

        dense = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick;
            chk(txd == 1'b1, "R1 mark while disabled", txd, 1);
        end

        dense = 1'b1; sync_char = 8'h00; char_len = 2'd3;
        tx_en = 1'b1; tick; tick;
        chk(txd == 1'b0, "R2 sync bit on line", txd, 0);
        tick;
        tx_en = 1'b0; tick;
        chk(txd == 1'b1, "R1 mark mid-character", txd, 1);

        run_msg(3, 2'd3, 1'b1, 1'b1, 1'b0, 8'h16);
        run_msg(4, 2'd0, 1'b1, 1'b1, 1'b1, 8'h0A);
        run_msg(2, 2'd2, 1'b1, 1'b0, 1'b0, 8'h32);
        run_msg(3, 2'd1, 1'b0, 1'b1, 1'b0, 8'h2D);
        for (int r = 0; r < 10; r++) begin
            dense = 1'($urandom);
            run_msg(1 + int'($urandom % 6), 2'($urandom), ($urandom % 4) != 0,
                    ($urandom % 4) != 0, (r % 3) == 0, 8'($urandom));
        end
        tx_en = 1'b0;
        tick;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule